// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block carries out one whole I2C master transaction, from the opening START to the closing STOP. A separate byte-level bit engine handles SCL timing and bit shifting. The sequencer sends that engine one operation at a time: START, repeated START, write a byte, read a byte, or STOP. It then waits for the engine to report completion before it issues the next operation.

A transaction begins with a one-cycle `cmd_go` pulse. The command fields give the address, one of four sequence kinds, a 10-bit address flag and two byte counts. Outgoing bytes arrive on a ready/valid stream. Received bytes leave on a valid-only stream. A signed three-bit status reports whether the transfer is running, finished cleanly or ended with one of several faults.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset the status is 0 (done). `eng_req`, `wr_ready` and `rd_valid` are all low.
- R2: Sequence code 0 (plain write) issues START, then the address byte with R/W=0, then every buffer-0 byte from the write stream, then STOP. Engine op codes are START=1, repeated START=2, WRITE=3, READ=4 and STOP=5.
- R3: Sequence code 1 (plain read) issues START, then the address byte with R/W=1, then buffer-0 count READ ops, then STOP. Every READ but the last carries `eng_rack`=0 (ACK). The last READ carries `eng_rack`=1 (NACK). Each received byte appears once on `rd_data` with `rd_valid` high, in order.
- R4: Sequence code 2 (write-read) writes the buffer-0 bytes, issues a repeated START, resends the first address byte with R/W=1, reads the buffer-1 bytes, then issues STOP.
- R5: Sequence code 3 (write-write) writes all buffer-0 bytes and then all buffer-1 bytes, with no repeated START between them, then issues STOP.
- R6: A write phase with a count of zero is legal. The transaction then carries only the address byte(s) after START.
- R7: If the read count is zero (buffer 0 for code 1, buffer 1 for code 2), the status becomes -4 one cycle after `cmd_go` and the engine receives no operation.
- R8: With 7-bit addressing the address byte is `{cmd_addr[7:1], rw}`. With 10-bit addressing the first byte is `{5'b11110, cmd_addr[10:9], rw}` and the second byte is `cmd_addr[8:1]`. After a repeated START only the first byte is resent.
- R9: A NACK on any address byte or written data byte is followed by STOP. The final status is then -1.
- R10: When the engine reports lost arbitration, the status becomes -3 and no further operation is issued, including STOP.
- R11: When the engine reports a bus error, the status becomes -2 and no further operation is issued.
- R12: While a transfer runs the status is +1. `cmd_go` pulses during that time are ignored. A clean finish gives status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Start pulse, accepted only when not busy |
| cmd_seq | input | 2 | Sequence kind: 0 write, 1 read, 2 write-read, 3 write-write |
| cmd_ten_bit | input | 1 | Use 10-bit addressing |
| cmd_addr | input | 11 | Address field (7-bit in [7:1], 10-bit in [10:1]) |
| cmd_len0 | input | LEN_W | Buffer-0 byte count |
| cmd_len1 | input | LEN_W | Buffer-1 byte count |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte present |
| wr_ready | output | 1 | Sequencer takes the write byte this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte valid (one cycle) |
| status | output | 3 | Signed status: +1 busy, 0 done, -1 NACK, -2 bus error, -3 arbitration lost, -4 usage fault |
| eng_req | output | 1 | One-cycle operation request to the bit engine |
| eng_op | output | 3 | Operation code |
| eng_wdata | output | 8 | Byte to transmit for WRITE |
| eng_rack | output | 1 | Acknowledge to send after READ (1 = NACK) |
| eng_done | input | 1 | Engine finished the requested operation |
| eng_nack | input | 1 | Slave NACKed the written byte |
| eng_arb_lost | input | 1 | Arbitration lost during the operation |
| eng_bus_err | input | 1 | Misplaced START/STOP seen during the operation |
| eng_rdata | input | 8 | Byte received by READ |

## Verification
The bench stands in for the bit engine and compares every requested operation against a list built from the requirements. The zero-count cases are the first target. A design that treats a zero write count as "one byte" would send a stray data byte. One that forgets the read check would start bus activity instead of faulting. NACK is injected both on the address and on a mid-stream data byte, because a design that skips STOP or keeps writing would show extra or missing operations. Arbitration loss and bus error are checked for the absence of a trailing STOP. A 10-bit write-read confirms that only the first address byte, with R/W set, follows the repeated START. Wrong ACK placement on the last read byte shows up directly in `eng_rack`.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int AFIELD_W = 11;
  localparam int BYTE_W   = 8;

  typedef enum logic [1:0] {
    SEQ_WR   = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WRRD = 2'd2,
    SEQ_WRWR = 2'd3
  } seq_e;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_START  = 3'd1,
    OP_RSTART = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4,
    OP_STOP   = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_AHI, S_ALO, S_XFER, S_RST, S_RADR, S_STOP
  } state_e;

  localparam logic signed [2:0] ST_BUSY   = 3'sd1;
  localparam logic signed [2:0] ST_DONE   = 3'sd0;
  localparam logic signed [2:0] ST_NACK   = -3'sd1;
  localparam logic signed [2:0] ST_BUSERR = -3'sd2;
  localparam logic signed [2:0] ST_ARB    = -3'sd3;
  localparam logic signed [2:0] ST_USAGE  = -3'sd4;
endpackage

// File: rtl/i2cs_addr_fmt.sv
module i2cs_addr_fmt
  import i2cs_pkg::*;
(
  input  logic [AFIELD_W-2:0] addr_bits,
  input  logic                ten,
  input  logic                rw,
  input  logic                lo_sel,
  output logic [BYTE_W-1:0]   abyte
);
  always_comb begin
    if (lo_sel)   abyte = addr_bits[7:0];
    else if (ten) abyte = {5'b11110, addr_bits[9:8], rw};
    else          abyte = {addr_bits[6:0], rw};
  end
endmodule

// File: rtl/i2cs_byte_ctr.sv
module i2cs_byte_ctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (dec && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == LEN_W'(1));
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2cs_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_go,
  input  logic [1:0]              cmd_seq,
  input  logic                    cmd_ten_bit,
  input  logic [10:0]             cmd_addr,
  input  logic [LEN_W-1:0]        cmd_len0,
  input  logic [LEN_W-1:0]        cmd_len1,
  input  logic [7:0]              wr_data,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  output logic [7:0]              rd_data,
  output logic                    rd_valid,
  output logic signed [2:0]       status,
  output logic                    eng_req,
  output logic [2:0]              eng_op,
  output logic [7:0]              eng_wdata,
  output logic                    eng_rack,
  input  logic                    eng_done,
  input  logic                    eng_nack,
  input  logic                    eng_arb_lost,
  input  logic                    eng_bus_err,
  input  logic [7:0]              eng_rdata
);
  state_e               st;
  seq_e                 seq;
  logic                 ten, pend, ph;
  logic [AFIELD_W-2:0]  abits;
  logic [LEN_W-1:0]     len0, len1;
  logic signed [2:0]    err;
  logic                 unused_addr_lsb;

  logic                 rd_dir, done_ok, wnack, enter, ab_trig, ab_ww;
  logic                 ld0, ld1, ctr_load, ctr_dec, ctr_last;
  logic [LEN_W-1:0]     ctr_val;
  state_e               ab_next;
  logic [7:0]           abyte;
  logic                 usage_bad;

  assign unused_addr_lsb = cmd_addr[0];

  // Decode of the current step
  always_comb begin
    rd_dir   = (seq == SEQ_RD) || (seq == SEQ_WRRD && ph);
    done_ok  = pend && eng_done && !eng_arb_lost && !eng_bus_err;
    wnack    = eng_nack && !(st == S_XFER && rd_dir);
    enter    = done_ok && !wnack && ((st == S_AHI && !ten) || st == S_ALO);
    ab_trig  = (enter && len0 == 0) ||
               (done_ok && st == S_XFER && ctr_last && !wnack);
    ab_ww    = !ph && seq == SEQ_WRWR && len1 != 0;
    ld0      = enter && len0 != 0;
    ld1      = (done_ok && st == S_RADR && !wnack) || (ab_trig && ab_ww);
    ctr_load = ld0 || ld1;
    ctr_val  = ld0 ? len0 : len1;
    ctr_dec  = done_ok && st == S_XFER;
    if (!ph && seq == SEQ_WRRD) ab_next = S_RST;
    else if (ab_ww)             ab_next = S_XFER;
    else                        ab_next = S_STOP;
    wr_ready  = (st == S_XFER) && !rd_dir && !pend;
    usage_bad = (cmd_seq == 2'd1 && cmd_len0 == 0) ||
                (cmd_seq == 2'd2 && cmd_len1 == 0);
  end

  i2cs_addr_fmt u_fmt (
    .addr_bits (abits),
    .ten       (ten),
    .rw        ((st == S_RADR) || (seq == SEQ_RD)),
    .lo_sel    (st == S_ALO),
    .abyte     (abyte)
  );

  i2cs_byte_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (ctr_load),
    .load_val (ctr_val),
    .dec      (ctr_dec),
    .last     (ctr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      seq       <= SEQ_WR;
      ten       <= 1'b0;
      abits     <= '0;
      len0      <= '0;
      len1      <= '0;
      pend      <= 1'b0;
      ph        <= 1'b0;
      err       <= ST_DONE;
      status    <= ST_DONE;
      eng_req   <= 1'b0;
      eng_op    <= OP_NONE;
      eng_wdata <= '0;
      eng_rack  <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      eng_req  <= 1'b0;
      rd_valid <= 1'b0;
      if (ld1) ph <= 1'b1;
      if (st == S_IDLE) begin
        if (cmd_go) begin
          seq   <= seq_e'(cmd_seq);
          ten   <= cmd_ten_bit;
          abits <= cmd_addr[AFIELD_W-1:1];
          len0  <= cmd_len0;
          len1  <= cmd_len1;
          ph    <= 1'b0;
          err   <= ST_DONE;
          if (usage_bad) status <= ST_USAGE;
          else begin
            status <= ST_BUSY;
            st     <= S_START;
          end
        end
      end else if (!pend) begin
        // Issue the operation that belongs to this step
        case (st)
          S_START: begin eng_op <= OP_START;  eng_req <= 1'b1; pend <= 1'b1; end
          S_RST:   begin eng_op <= OP_RSTART; eng_req <= 1'b1; pend <= 1'b1; end
          S_STOP:  begin eng_op <= OP_STOP;   eng_req <= 1'b1; pend <= 1'b1; end
          S_AHI, S_ALO, S_RADR: begin
            eng_op    <= OP_WRITE;
            eng_wdata <= abyte;
            eng_req   <= 1'b1;
            pend      <= 1'b1;
          end
          S_XFER: begin
            if (rd_dir) begin
              eng_op   <= OP_READ;
              eng_rack <= ctr_last;
              eng_req  <= 1'b1;
              pend     <= 1'b1;
            end else if (wr_valid) begin
              eng_op    <= OP_WRITE;
              eng_wdata <= wr_data;
              eng_req   <= 1'b1;
              pend      <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (eng_done) begin
        pend <= 1'b0;
        if (eng_arb_lost) begin
          status <= ST_ARB;
          st     <= S_IDLE;
        end else if (eng_bus_err) begin
          status <= ST_BUSERR;
          st     <= S_IDLE;
        end else begin
          case (st)
            S_START: st <= S_AHI;
            S_RST:   st <= S_RADR;
            S_AHI, S_ALO, S_RADR: begin
              if (wnack) begin
                err <= ST_NACK;
                st  <= S_STOP;
              end else if (st == S_AHI && ten) st <= S_ALO;
              else if (st == S_RADR)            st <= S_XFER;
              else if (len0 != 0)               st <= S_XFER;
              else                              st <= ab_next;
            end
            S_XFER: begin
              if (rd_dir) begin
                rd_valid <= 1'b1;
                rd_data  <= eng_rdata;
              end
              if (wnack) begin
                err <= ST_NACK;
                st  <= S_STOP;
              end else if (ctr_last) st <= ab_next;
            end
            S_STOP: begin
              status <= err;
              st     <= S_IDLE;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
  import i2cs_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_go,
  input logic [1:0]        cmd_seq,
  input logic [LEN_W-1:0]  cmd_len0,
  input logic [LEN_W-1:0]  cmd_len1,
  input logic              eng_req,
  input logic              eng_done,
  input logic              eng_arb_lost,
  input logic              eng_bus_err,
  input logic              rd_valid,
  input logic              wr_ready,
  input logic signed [2:0] status
);
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    eng_req |-> status == ST_BUSY); // R12

  AST_WREADY_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> status == ST_BUSY); // R12

  AST_RDVALID_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(eng_done)); // R3

  AST_EMPTY_READ_FAULT: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && status != ST_BUSY &&
     ((cmd_seq == 2'd1 && cmd_len0 == 0) || (cmd_seq == 2'd2 && cmd_len1 == 0)))
    |=> (status == ST_USAGE && !eng_req)); // R7

  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (status == ST_BUSY && eng_done && eng_arb_lost)
    |=> (status == ST_ARB && !eng_req)); // R10

  AST_BUSERR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (status == ST_BUSY && eng_done && eng_bus_err && !eng_arb_lost)
    |=> (status == ST_BUSERR && !eng_req)); // R11
endmodule

bind i2c_xfer_seq i2cs_chk #(.LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_go       (cmd_go),
  .cmd_seq      (cmd_seq),
  .cmd_len0     (cmd_len0),
  .cmd_len1     (cmd_len1),
  .eng_req      (eng_req),
  .eng_done     (eng_done),
  .eng_arb_lost (eng_arb_lost),
  .eng_bus_err  (eng_bus_err),
  .rd_valid     (rd_valid),
  .wr_ready     (wr_ready),
  .status       (status)
);

// File: tb/i2c_xfer_seq_tb.sv
module i2c_xfer_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 8;

  logic clk = 0, rst = 1;
  logic cmd_go = 0, cmd_ten_bit = 0;
  logic [1:0] cmd_seq = 0;
  logic [10:0] cmd_addr = 0;
  logic [LEN_W-1:0] cmd_len0 = 0, cmd_len1 = 0;
  logic [7:0] wr_data = 0;
  logic wr_valid = 0, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid;
  logic signed [2:0] status;
  logic eng_req, eng_rack;
  logic [2:0] eng_op;
  logic [7:0] eng_wdata;
  logic eng_done = 0, eng_nack = 0, eng_arb_lost = 0, eng_bus_err = 0;
  logic [7:0] eng_rdata = 0;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  logic [11:0] expq[$];
  logic [7:0]  wq[$];
  logic [7:0]  rdq[$];
  int fault_idx = -1, fault_kind = 0, op_idx = 0;
  logic [7:0] rd_seed = 8'h30, wbase = 8'hC0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_xfer_seq #(.LEN_W(LEN_W)) u_dut (.*);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] item(int op, int b, bit r);
    return {op[2:0], b[7:0], r};
  endfunction

  // Bit-engine model and operation scoreboard
  initial begin
    forever begin
      @(posedge clk); #1;
      if (eng_req) begin
        automatic logic [11:0] act = item(eng_op, (eng_op == 3'd3) ? eng_wdata : 0,
                                          (eng_op == 3'd4) ? eng_rack : 1'b0);
        automatic int k = op_idx;
        automatic logic [7:0] rv = rd_seed;
        if (expq.size() == 0) chk(0, cur_req, "unexpected engine op", act, 0);
        else begin
          automatic logic [11:0] e = expq.pop_front();
          chk(act == e, cur_req, "engine op {op,byte,ack}", act, e);
        end
        op_idx++;
        if (eng_op == 3'd4) begin rdq.push_back(rd_seed); rd_seed++; end
        @(posedge clk); #1;
        eng_done = 1; eng_rdata = rv;
        eng_nack     = (k == fault_idx && fault_kind == 1);
        eng_arb_lost = (k == fault_idx && fault_kind == 2);
        eng_bus_err  = (k == fault_idx && fault_kind == 3);
        @(posedge clk); #1;
        eng_done = 0; eng_nack = 0; eng_arb_lost = 0; eng_bus_err = 0;
      end
    end
  end

  // Write stream source
  initial begin
    forever begin
      automatic bit hs;
      @(negedge clk);
      hs = wr_ready && wr_valid;
      @(posedge clk); #1;
      if (hs && wq.size() > 0) void'(wq.pop_front());
      wr_valid = (wq.size() > 0);
      wr_data  = (wq.size() > 0) ? wq[0] : 8'h00;
    end
  end

  // Read stream monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rd_valid) begin
        if (rdq.size() == 0) chk(0, "R3", "unexpected rd_valid", rd_data, 0);
        else begin
          automatic logic [7:0] e = rdq.pop_front();
          chk(rd_data == e, "R3", "read byte", rd_data, e);
        end
      end
    end
  end

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_sim();
  end

  task automatic run(string req, int seq, bit ten, int addr, int l0, int l1,
                     int fidx, int fkind, int exp_st, bit poke);
    logic [11:0] full[$];
    int hib, hirb;
    bit fault_exp;
    fault_exp = (seq == 1 && l0 == 0) || (seq == 2 && l1 == 0);
    hib  = ten ? {5'b11110, addr[9:8], (seq == 1)} : {addr[6:0], (seq == 1)};
    hirb = ten ? {5'b11110, addr[9:8], 1'b1} : {addr[6:0], 1'b1};
    if (!fault_exp) begin
      full.push_back(item(1, 0, 0));
      full.push_back(item(3, hib, 0));
      if (ten) full.push_back(item(3, addr[7:0], 0));
      for (int j = 0; j < l0; j++) begin
        if (seq == 1) full.push_back(item(4, 0, j == l0 - 1));
        else begin full.push_back(item(3, wbase, 0)); wq.push_back(wbase); wbase++; end
      end
      if (seq == 2) begin
        full.push_back(item(2, 0, 0));
        full.push_back(item(3, hirb, 0));
        for (int j = 0; j < l1; j++) full.push_back(item(4, 0, j == l1 - 1));
      end
      if (seq == 3)
        for (int j = 0; j < l1; j++) begin
          full.push_back(item(3, wbase, 0)); wq.push_back(wbase); wbase++;
        end
      full.push_back(item(5, 0, 0));
    end
    expq.delete();
    foreach (full[i]) begin
      if (fidx >= 0 && i > fidx) break;
      expq.push_back(full[i]);
      if (i == fidx && fkind == 1) expq.push_back(item(5, 0, 0));
    end
    cur_req = req; op_idx = 0; fault_idx = fidx; fault_kind = fkind;
    cmd_seq = seq[1:0]; cmd_ten_bit = ten;
    cmd_addr = ten ? {addr[9:0], 1'b0} : {3'b000, addr[6:0], 1'b0};
    cmd_len0 = l0[LEN_W-1:0]; cmd_len1 = l1[LEN_W-1:0];
    cmd_go = 1;
    @(posedge clk); #1;
    cmd_go = 0;
    if (!fault_exp) chk(status == 1, "R12", "status while running", status, 1);
    for (int n = 0; n < 2000 && status == 1; n++) begin
      if (poke && n == 3) begin cmd_seq = 2'd1; cmd_len0 = 0; cmd_go = 1; end
      if (poke && n == 4) cmd_go = 0;
      @(posedge clk); #1;
    end
    cmd_go = 0;
    repeat (6) @(posedge clk); #1;
    chk(int'(status) == exp_st, req, "final status", status, exp_st);
    chk(expq.size() == 0, req, "operations left unissued", expq.size(), 0);
    wq.delete(); fault_idx = -1; fault_kind = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 0;
    chk(status == 0, "R1", "status after reset", status, 0);
    chk(!eng_req && !wr_ready && !rd_valid, "R1", "idle outputs after reset",
        {eng_req, wr_ready, rd_valid}, 0);
    run("R2", 0, 0, 'h50, 2, 0, -1, 0, 0, 0);
    run("R3", 1, 0, 'h3C, 3, 0, -1, 0, 0, 0);
    run("R4", 2, 0, 'h21, 1, 2, -1, 0, 0, 0);
    run("R5", 3, 0, 'h11, 1, 2, -1, 0, 0, 0);
    run("R6", 0, 0, 'h2B, 0, 0, -1, 0, 0, 0);
    run("R6", 3, 0, 'h2B, 0, 0, -1, 0, 0, 0);
    run("R7", 1, 0, 'h10, 0, 0, -1, 0, -4, 0);
    run("R7", 2, 0, 'h10, 1, 0, -1, 0, -4, 0);
    run("R8", 2, 1, 'h2A5, 2, 1, -1, 0, 0, 0);
    run("R8", 0, 1, 'h15A, 1, 0, -1, 0, 0, 0);
    run("R9", 0, 0, 'h40, 3, 0, 1, 1, -1, 0);
    run("R9", 0, 0, 'h40, 3, 0, 3, 1, -1, 0);
    run("R10", 0, 0, 'h40, 2, 0, 1, 2, -3, 0);
    run("R11", 1, 0, 'h40, 2, 0, 0, 3, -2, 0);
    run("R12", 0, 0, 'h33, 4, 0, -1, 0, 0, 1);
    chk(rdq.size() == 0, "R3", "read bytes not delivered", rdq.size(), 0);
    finish_sim();
  end
endmodule